// File: doc/BRIEF.md
# IPv4 Fragmentation Descriptor Sequencer

This block turns the parsed parameters of one IPv4 packet into a run of fragment descriptors. It takes the header word count, the total length, the don't-fragment flag, the incoming offset field, the MTU of the outgoing path, and the byte size of the options that every fragment must repeat. It then walks the payload and emits one descriptor per fragment over a valid/ready handshake. Each descriptor gives the offset field, the more-fragments flag, the total length, where the fragment's payload starts in the original payload, how many bytes it carries, and a 32-bit kind code. The downstream pipeline uses the kind code to pick how it rebuilds the header.

The first fragment keeps the complete original header. Every later fragment uses a reduced header: the 20-byte fixed part plus the must-copy options only. The payload is sliced in 8-byte blocks, so each fragment fits within the MTU. If the packet is too large but may not be fragmented, no descriptor is produced. Instead, a one-cycle request for a destination-unreachable message is raised.

Top module: `ipv4_frag_seq`

## Requirements
- R1: `inReady` is high only when the block is idle. An input is taken on a clock edge where `inValid` and `inReady` are both high. An `inValid` raised while the block is busy has no effect on the descriptors being produced.
- R2: When the total length is not greater than the MTU, exactly one descriptor is produced. It has kind 0xABCDEFAD, more-fragments 0, the incoming offset, the incoming total length, payload start 0, and payload length equal to total length minus 4×header words.
- R3: When the total length is greater than the MTU and don't-fragment is set, no descriptor is produced. `icmpValid` pulses for one cycle with `icmpType` = 3 and `icmpCode` = 4, in the same cycle as `done`.
- R4: The first fragment of a fragmented packet carries B = (MTU − 4×header words) >> 3 blocks, so its payload length is 8×B. Its total length is 4×header words + 8×B, with more-fragments 1, payload start 0, the incoming offset, and kind 0xABCDEFAB.
- R5: A later fragment has header size H = 20 + must-copy option bytes. If H plus the remaining payload is greater than the MTU, it carries ((MTU − H) >> 3)×8 bytes with more-fragments 1 and kind 0xABCDEFAC. Otherwise it carries the whole remaining payload with more-fragments 0 and kind 0xABCDEFAA. Its total length is H plus its payload length.
- R6: Each later fragment's offset equals the previous fragment's offset plus the previous payload length divided by 8. Its payload start equals the previous start plus the previous payload length.
- R7: Fragments stop once the remaining payload reaches zero. The payload lengths of all fragments add up to the original payload size.
- R8: While `outValid` is high and `outReady` is low, `outValid` and every descriptor field stay unchanged.
- R9: `done` pulses for one cycle. It follows the clock edge that accepts the final descriptor of a packet, or the edge that decides on the unreachable request.
- R10: Every descriptor's total length is at most the MTU.
- R11: The first descriptor of a packet, or the unreachable request, appears two clock edges after the input is accepted. Each following descriptor appears two edges after the previous one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Packet parameters present |
| inReady | output | 1 | Block idle, parameters will be taken |
| inHdrWords | input | 4 | Header length in 32-bit words |
| inTotalLen | input | 16 | Packet total length in bytes |
| inDontFrag | input | 1 | Don't-fragment flag |
| inFragOffset | input | 13 | Incoming fragment offset field |
| inMtu | input | 16 | MTU of the outgoing path (at least 68) |
| inCopyOptLen | input | 16 | Byte size of options copied to every fragment |
| outValid | output | 1 | Descriptor present |
| outReady | input | 1 | Consumer takes descriptor |
| outFragOffset | output | 13 | Fragment offset field |
| outMoreFrags | output | 1 | More-fragments flag |
| outTotalLen | output | 16 | Fragment total length |
| outPayStart | output | 16 | Byte position of the fragment's payload in the original payload |
| outPayLen | output | 16 | Fragment payload bytes |
| outKind | output | 32 | Fragment kind code |
| icmpValid | output | 1 | Destination-unreachable request pulse |
| icmpType | output | 8 | Message type (3 while requested, else 0) |
| icmpCode | output | 8 | Message code (4 while requested, else 0) |
| done | output | 1 | Packet finished pulse |

## Verification
After the accepting edge, the bench looks at the next falling edge and expects `outValid` low, since the decision register is still settling. At the falling edge after that it expects the first descriptor or the unreachable request. Later descriptors go through a scoreboard that compares each one at the falling edge where `outValid` and `outReady` are both high. Because `outReady` changes just after rising edges, every sample is taken half a period away from the edge that moves the state. `done` and the request pulse are counted at falling edges and compared once each packet has drained.

// File: rtl/frag_pkg.sv
package frag_pkg;
  localparam int LEN_W  = 16;
  localparam int OFF_W  = 13;
  localparam int KIND_W = 32;

  localparam logic [KIND_W-1:0] KIND_FIRST = 32'hABCDEFAB;
  localparam logic [KIND_W-1:0] KIND_LAST  = 32'hABCDEFAA;
  localparam logic [KIND_W-1:0] KIND_MID   = 32'hABCDEFAC;
  localparam logic [KIND_W-1:0] KIND_WHOLE = 32'hABCDEFAD;

  typedef struct packed {
    logic load;
    logic buildWhole;
    logic buildFirst;
    logic buildNext;
    logic advance;
  } strobe_t;
endpackage

// File: rtl/frag_ctrl.sv
module frag_ctrl
  import frag_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  input  logic    outReady,
  output logic    outValid,
  input  logic    fragNeeded,
  input  logic    dfSet,
  input  logic    lastDesc,
  output strobe_t stb,
  output logic    done,
  output logic    icmpValid
);
  typedef enum logic [1:0] {S_IDLE, S_DECIDE, S_SEND, S_NEXT} state_t;
  state_t state, stateNext;
  logic doneNext, icmpNext;

  always_comb begin
    stateNext = state;
    stb       = '0;
    doneNext  = 1'b0;
    icmpNext  = 1'b0;
    unique case (state)
      S_IDLE: if (inValid) begin
        stb.load  = 1'b1;
        stateNext = S_DECIDE;
      end
      S_DECIDE: begin
        if (!fragNeeded) begin
          stb.buildWhole = 1'b1;
          stateNext      = S_SEND;
        end else if (dfSet) begin
          icmpNext  = 1'b1;
          doneNext  = 1'b1;
          stateNext = S_IDLE;
        end else begin
          stb.buildFirst = 1'b1;
          stateNext      = S_SEND;
        end
      end
      S_SEND: if (outReady) begin
        stb.advance = 1'b1;
        if (lastDesc) begin
          doneNext  = 1'b1;
          stateNext = S_IDLE;
        end else begin
          stateNext = S_NEXT;
        end
      end
      S_NEXT: begin
        stb.buildNext = 1'b1;
        stateNext     = S_SEND;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      done      <= 1'b0;
      icmpValid <= 1'b0;
    end else begin
      state     <= stateNext;
      done      <= doneNext;
      icmpValid <= icmpNext;
    end
  end

  assign inReady  = (state == S_IDLE);
  assign outValid = (state == S_SEND);

  assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);
  assert_idle_only_R1: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !outValid);
  assert_icmp_with_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    icmpValid |-> done && !outValid);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done || $past(inValid && inReady) == 1'b0);
endmodule

// File: rtl/frag_dp.sv
module frag_dp
  import frag_pkg::*;
#(
  parameter int HW_W     = 4,
  parameter int BASE_HDR = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [HW_W-1:0]   inHdrWords,
  input  logic [LEN_W-1:0]  inTotalLen,
  input  logic              inDontFrag,
  input  logic [OFF_W-1:0]  inFragOffset,
  input  logic [LEN_W-1:0]  inMtu,
  input  logic [LEN_W-1:0]  inCopyOptLen,
  input  logic              outValid,
  input  logic              outReady,
  output logic              fragNeeded,
  output logic              dfSet,
  output logic              lastDesc,
  output logic [OFF_W-1:0]  dOff,
  output logic              dMf,
  output logic [LEN_W-1:0]  dTotal,
  output logic [LEN_W-1:0]  dStart,
  output logic [LEN_W-1:0]  dLen,
  output logic [KIND_W-1:0] dKind
);
  logic [LEN_W-1:0] hdrBytesQ, totalQ, mtuQ, laterHdrQ, remQ, startQ;
  logic [OFF_W-1:0] offQ;
  logic             dfQ;

  logic [LEN_W-1:0] firstBlocks, firstLen, midBlocks, midLen, nextLen;
  logic [LEN_W:0]   nextSum;
  logic             nextFits;

  always_comb begin
    firstBlocks = (mtuQ - hdrBytesQ) >> 3;
    firstLen    = firstBlocks << 3;
    midBlocks   = (mtuQ - laterHdrQ) >> 3;
    midLen      = midBlocks << 3;
    nextSum     = {1'b0, laterHdrQ} + {1'b0, remQ};
    nextFits    = nextSum <= {1'b0, mtuQ};
    nextLen     = nextFits ? remQ : midLen;
  end

  assign fragNeeded = totalQ > mtuQ;
  assign dfSet      = dfQ;
  assign lastDesc   = !dMf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrBytesQ <= '0;
      totalQ    <= '0;
      mtuQ      <= '0;
      laterHdrQ <= '0;
      remQ      <= '0;
      startQ    <= '0;
      offQ      <= '0;
      dfQ       <= 1'b0;
    end else if (stb.load) begin
      hdrBytesQ <= LEN_W'({inHdrWords, 2'b00});
      totalQ    <= inTotalLen;
      mtuQ      <= inMtu;
      laterHdrQ <= LEN_W'(BASE_HDR) + inCopyOptLen;
      remQ      <= inTotalLen - LEN_W'({inHdrWords, 2'b00});
      startQ    <= '0;
      offQ      <= inFragOffset;
      dfQ       <= inDontFrag;
    end else if (stb.advance) begin
      remQ   <= remQ - dLen;
      startQ <= startQ + dLen;
      offQ   <= offQ + OFF_W'(dLen >> 3);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dOff   <= '0;
      dMf    <= 1'b0;
      dTotal <= '0;
      dStart <= '0;
      dLen   <= '0;
      dKind  <= '0;
    end else if (stb.buildWhole) begin
      dOff   <= offQ;
      dMf    <= 1'b0;
      dTotal <= totalQ;
      dStart <= '0;
      dLen   <= remQ;
      dKind  <= KIND_WHOLE;
    end else if (stb.buildFirst) begin
      dOff   <= offQ;
      dMf    <= 1'b1;
      dTotal <= hdrBytesQ + firstLen;
      dStart <= '0;
      dLen   <= firstLen;
      dKind  <= KIND_FIRST;
    end else if (stb.buildNext) begin
      dOff   <= offQ;
      dMf    <= !nextFits;
      dTotal <= laterHdrQ + nextLen;
      dStart <= startQ;
      dLen   <= nextLen;
      dKind  <= nextFits ? KIND_LAST : KIND_MID;
    end
  end

  assert_fits_mtu_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> dTotal <= mtuQ);
  assert_stable_desc_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(dOff) && $stable(dMf) && $stable(dTotal)
      && $stable(dStart) && $stable(dLen) && $stable(dKind));
  assert_block_multiple_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && dMf |-> dLen[2:0] == 3'b000);
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> dLen <= remQ);
endmodule

// File: rtl/ipv4_frag_seq.sv
module ipv4_frag_seq
  import frag_pkg::*;
#(
  parameter int HW_W     = 4,
  parameter int BASE_HDR = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [HW_W-1:0]   inHdrWords,
  input  logic [LEN_W-1:0]  inTotalLen,
  input  logic              inDontFrag,
  input  logic [OFF_W-1:0]  inFragOffset,
  input  logic [LEN_W-1:0]  inMtu,
  input  logic [LEN_W-1:0]  inCopyOptLen,
  output logic              outValid,
  input  logic              outReady,
  output logic [OFF_W-1:0]  outFragOffset,
  output logic              outMoreFrags,
  output logic [LEN_W-1:0]  outTotalLen,
  output logic [LEN_W-1:0]  outPayStart,
  output logic [LEN_W-1:0]  outPayLen,
  output logic [KIND_W-1:0] outKind,
  output logic              icmpValid,
  output logic [7:0]        icmpType,
  output logic [7:0]        icmpCode,
  output logic              done
);
  strobe_t stb;
  logic    fragNeeded, dfSet, lastDesc;

  frag_ctrl u_ctrl (
    .clk, .rstN, .inValid, .inReady, .outReady, .outValid,
    .fragNeeded, .dfSet, .lastDesc, .stb, .done, .icmpValid
  );

  frag_dp #(.HW_W(HW_W), .BASE_HDR(BASE_HDR)) u_dp (
    .clk, .rstN, .stb, .inHdrWords, .inTotalLen, .inDontFrag, .inFragOffset,
    .inMtu, .inCopyOptLen, .outValid, .outReady, .fragNeeded, .dfSet, .lastDesc,
    .dOff(outFragOffset), .dMf(outMoreFrags), .dTotal(outTotalLen),
    .dStart(outPayStart), .dLen(outPayLen), .dKind(outKind)
  );

  assign icmpType = icmpValid ? 8'd3 : 8'd0;
  assign icmpCode = icmpValid ? 8'd4 : 8'd0;
endmodule

// File: tb/sim_ipv4_frag_seq.sv
module sim_ipv4_frag_seq;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [12:0] off;
    logic        mf;
    logic [15:0] tot;
    logic [15:0] start;
    logic [15:0] len;
    logic [31:0] kind;
  } exp_t;

  logic clk = 0, rstN = 0;
  logic inValid = 0, inReady, inDontFrag = 0, outValid, outReady = 0;
  logic [3:0]  inHdrWords = 0;
  logic [15:0] inTotalLen = 0, inMtu = 0, inCopyOptLen = 0;
  logic [12:0] inFragOffset = 0, outFragOffset;
  logic        outMoreFrags, icmpValid, done;
  logic [15:0] outTotalLen, outPayStart, outPayLen;
  logic [31:0] outKind;
  logic [7:0]  icmpType, icmpCode;

  int   testCnt = 0, failCnt = 0, doneCnt = 0, icmpCnt = 0;
  int   curMtu = 0;
  exp_t q[$];
  logic [15:0] lfsr = 16'hACE1;
  logic readyAlways = 1;

  ipv4_frag_seq u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // consumer ready pattern, changed just after rising edges
  initial forever begin
    @(posedge clk); #1;
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    outReady = readyAlways | lfsr[0];
  end

  // monitor / scoreboard
  exp_t held;
  bit   wasHeld = 0;
  initial forever begin
    @(negedge clk);
    if (!rstN) continue;
    if (done) doneCnt++;
    if (icmpValid) icmpCnt++;
    if (wasHeld) begin
      check(outValid && {outFragOffset, outMoreFrags, outTotalLen, outPayStart,
            outPayLen, outKind} == held, "R8", "held descriptor",
            {outFragOffset, outTotalLen}, {held.off, held.tot});
    end
    wasHeld = outValid && !outReady;
    held    = {outFragOffset, outMoreFrags, outTotalLen, outPayStart, outPayLen, outKind};
    if (outValid && outReady) begin
      if (q.size() == 0) begin
        check(0, "R7", "unexpected descriptor kind", outKind, 0);
      end else begin
        exp_t e;
        string tag;
        e = q.pop_front();
        tag = (e.kind == 32'hABCDEFAD) ? "R2" : (e.kind == 32'hABCDEFAB) ? "R4" : "R5/R6";
        check(outKind == e.kind, tag, "kind", outKind, e.kind);
        check(outMoreFrags == e.mf && outFragOffset == e.off && outPayStart == e.start,
              tag, "mf/offset/start", {outMoreFrags, outFragOffset, outPayStart},
              {e.mf, e.off, e.start});
        check(outTotalLen == e.tot && outPayLen == e.len, tag, "total/len",
              {outTotalLen, outPayLen}, {e.tot, e.len});
        check(int'(outTotalLen) <= curMtu, "R10", "total within mtu", outTotalLen, curMtu);
      end
    end
  end

  task automatic sendPacket(input int ihl, input int tot, input bit df, input int off,
                            input int mtu, input int copy, input bit poke);
    int hdr = ihl * 4, pay = tot - ihl * 4, d0 = doneCnt, i0 = icmpCnt;
    bit expIcmp = 0;
    int waitCnt = 0;
    if (tot <= mtu) begin
      q.push_back({13'(off), 1'b0, 16'(tot), 16'd0, 16'(pay), 32'hABCDEFAD});
    end else if (df) begin
      expIcmp = 1;
    end else begin
      int len = ((mtu - hdr) / 8) * 8;
      int rem = pay - len, o = off + len / 8, st = len, lh = 20 + copy;
      q.push_back({13'(off), 1'b1, 16'(hdr + len), 16'd0, 16'(len), 32'hABCDEFAB});
      while (rem > 0) begin
        bit mf;
        logic [31:0] k;
        if (lh + rem > mtu) begin len = ((mtu - lh) / 8) * 8; mf = 1; k = 32'hABCDEFAC; end
        else begin len = rem; mf = 0; k = 32'hABCDEFAA; end
        q.push_back({13'(o), mf, 16'(lh + len), 16'(st), 16'(len), k});
        rem -= len; o += len / 8; st += len;
      end
    end
    @(negedge clk);
    while (!inReady) @(negedge clk);
    curMtu = mtu;
    inValid = 1; inHdrWords = 4'(ihl); inTotalLen = 16'(tot); inDontFrag = df;
    inFragOffset = 13'(off); inMtu = 16'(mtu); inCopyOptLen = 16'(copy);
    @(posedge clk); #1 inValid = 0;
    @(negedge clk);
    check(!outValid && !icmpValid, "R11", "nothing one edge after accept", outValid, 0);
    @(negedge clk);
    if (expIcmp) begin
      check(icmpValid && done && icmpType == 8'd3 && icmpCode == 8'd4 && !outValid, "R3",
            "unreachable request", {icmpValid, done, icmpType, icmpCode}, {2'b11, 8'd3, 8'd4});
    end else begin
      check(outValid, "R11", "first descriptor two edges after accept", outValid, 1);
    end
    if (poke) begin
      @(negedge clk);
      check(!inReady, "R1", "busy not ready", inReady, 0);
      inValid = 1; inTotalLen = 16'd9999; inMtu = 16'd100; inFragOffset = 13'd77;
      @(posedge clk); #1 inValid = 0;
    end
    while (doneCnt == d0 && waitCnt < 5000) begin @(negedge clk); waitCnt++; end
    repeat (3) @(negedge clk);
    check(doneCnt == d0 + 1, "R9", "done pulses", doneCnt - d0, 1);
    check(icmpCnt == i0 + int'(expIcmp), "R3", "request pulses", icmpCnt - i0, expIcmp);
    check(q.size() == 0, "R7", "all descriptors seen", q.size(), 0);
    q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCnt++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(inReady && !outValid && !done && !icmpValid, "R1", "reset state",
          {inReady, outValid, done, icmpValid}, 4'b1000);
    sendPacket(5, 500, 0, 0, 576, 0, 0);     // R2 fits
    sendPacket(5, 576, 1, 12, 576, 0, 0);    // R2 boundary: equal, df ignored
    sendPacket(5, 1000, 1, 0, 576, 0, 0);    // R3
    sendPacket(9, 600, 0, 0, 576, 16, 0);    // R4 R5 two fragments with options
    readyAlways = 0;
    sendPacket(5, 4000, 0, 0, 576, 0, 1);    // R5 R6 R8 many middles, busy poke R1
    sendPacket(5, 69, 0, 0, 68, 0, 0);       // R7 one byte left
    sendPacket(15, 1500, 0, 0, 100, 40, 0);  // R5 large reduced header
    sendPacket(6, 3000, 0, 100, 1500, 8, 0); // R6 nonzero base offset
    readyAlways = 1;
    sendPacket(5, 1500, 0, 0, 576, 12, 0);   // R11 back-to-back acceptance
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule